// File: doc/BRIEF.md
# Frame sync format detector

This block sits next to the serial shift registers of a time-slot switch. It watches the frame pulse that arrives with the serial streams. From the shape of that pulse it works out which framing is in use. An active-low pulse means most-significant-bit-first framing. An active-high pulse means least-significant-bit-first framing. The block then runs the channel and bit counters of the frame. A frame has 32 channels of 8 bits, and each bit lasts two clocks of the bit clock. The block also gives the drive and sample strobes that the shifters use.

A pulse is one clock wide and has the idle level on both sides of it. The clock edge that samples the first idle level after a pulse starts a new frame. The format the block reports changes only when two pulses in a row have the same polarity and come exactly one frame apart. Until that happens, the not-locked flag stays raised. If a pulse goes missing, the counters keep running on their own but the lock is dropped. If a pulse arrives at the wrong place, the counters realign to it.

Top module: `frame_fmt_detect`

## Requirements
- R1: While reset is held and until the first pulse, not_locked_o is 1, fmt_o is 0, frame_start_o, drive_stb_o and sample_stb_o are 0, and chan_o is 0.
- R2: fmt_o encodes the locked format: 0 = active-low pulse with MSB-first bits, 1 = active-high pulse with LSB-first bits. lsb_first_o equals fmt_o.
- R3: The clock edge that samples the first idle level after a one-clock pulse puts the counters at channel 0, bit 0, phase 0. frame_start_o is 1 for that one cycle.
- R4: After a pulse, each bit takes two clocks. drive_stb_o is 1 on the first clock of a bit and sample_stb_o is 1 on the second. chan_o goes up by one every 16 clocks and wraps after channel 31, so one frame is 512 clocks.
- R5: bit_idx_o counts 0 to 7 within a channel when fmt_o is 1. It counts 7 down to 0 when fmt_o is 0.
- R6: Lock (not_locked_o = 0) is set, and fmt_o is updated, only on a pulse that comes exactly 512 clocks after a previous pulse of the same polarity. fmt_o changes at no other time.
- R7: A pulse whose polarity differs from the previous pulse clears the lock and leaves fmt_o unchanged.
- R8: If a frame ends with no pulse, the counters wrap and frame_start_o still fires, but not_locked_o becomes 1.
- R9: A pulse at any position other than the frame end realigns the counters to channel 0 and clears the lock. An aligned pulse of the same polarity one frame later locks again.
- R10: Before the first pulse the counters hold at zero and neither strobe is raised, even when the frame pulse input stays idle for a long time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock, two cycles per serial bit |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fp_i | input | 1 | Frame pulse, either polarity |
| fmt_o | output | 1 | Locked format: 0 active-low/MSB-first, 1 active-high/LSB-first |
| not_locked_o | output | 1 | High until two aligned pulses agree |
| frame_start_o | output | 1 | High on the first clock of a frame |
| chan_o | output | 5 | Current channel, 0 to 31 |
| bit_idx_o | output | 3 | Bit position within the channel byte |
| lsb_first_o | output | 1 | Bit order to use, 1 = LSB first |
| drive_stb_o | output | 1 | First clock of a bit: output shifters change |
| sample_stb_o | output | 1 | Second clock of a bit: input shifters sample |

## Verification
Every result is due one clock edge after the edge at which fp_i shows the first idle level after a pulse. On that edge the counters clear, frame_start_o rises, and the lock flag and format update, all together. When no pulse has arrived, the counters move by one step at each rising edge. The bench drives fp_i at the falling edge. It advances its own model by exactly one rising edge for each value it drives, and it compares all outputs at the next falling edge. Directed checks read values that were captured in the first cycle of each new frame.

// File: rtl/fsd_pkg.sv
package fsd_pkg;
  // Framing decided from the frame pulse polarity
  typedef enum logic {
    FMT_MSB_FIRST = 1'b0,  // active-low pulse
    FMT_LSB_FIRST = 1'b1   // active-high pulse
  } frame_fmt_e;
endpackage

// File: rtl/fsd_pulse_classifier.sv
module fsd_pulse_classifier
  import fsd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fp_i,
  output logic       det_o,
  output frame_fmt_e cand_o
);
  logic fp_d1_q, fp_d2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fp_d1_q <= 1'b0;
      fp_d2_q <= 1'b0;
    end else begin
      fp_d1_q <= fp_i;
      fp_d2_q <= fp_d1_q;
    end
  end

  // One-clock pulse bounded by the idle level on both sides
  logic hi_pulse, lo_pulse;
  always_comb begin
    hi_pulse = !fp_d2_q &&  fp_d1_q && !fp_i;
    lo_pulse =  fp_d2_q && !fp_d1_q &&  fp_i;
    det_o    = hi_pulse || lo_pulse;
    cand_o   = hi_pulse ? FMT_LSB_FIRST : FMT_MSB_FIRST;
  end

  // R2: a detected pulse is never both polarities
  a_r2_single_polarity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({hi_pulse, lo_pulse}) <= 1);
endmodule

// File: rtl/fsd_frame_counter.sv
module fsd_frame_counter
  import fsd_pkg::*;
#(
  parameter  int CHANNELS     = 32,
  parameter  int BITS_PER_CH  = 8,
  parameter  int CLKS_PER_BIT = 2,
  localparam int CH_W  = $clog2(CHANNELS),
  localparam int BIT_W = $clog2(BITS_PER_CH),
  localparam int PH_W  = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             det_i,
  input  logic             lsb_first_i,
  output logic             wrap_o,
  output logic             frame_start_o,
  output logic [CH_W-1:0]  chan_o,
  output logic [BIT_W-1:0] bit_idx_o,
  output logic             drive_stb_o,
  output logic             sample_stb_o
);
  localparam logic [PH_W-1:0]  PH_LAST   = PH_W'(CLKS_PER_BIT - 1);
  localparam logic [PH_W-1:0]  PH_SAMPLE = PH_W'(CLKS_PER_BIT / 2);
  localparam logic [BIT_W-1:0] BIT_LAST  = BIT_W'(BITS_PER_CH - 1);
  localparam logic [CH_W-1:0]  CH_LAST   = CH_W'(CHANNELS - 1);

  logic [PH_W-1:0]  ph_q,  ph_n;
  logic [BIT_W-1:0] bit_q, bit_n;
  logic [CH_W-1:0]  ch_q,  ch_n;
  logic             synced_q, synced_n;
  logic             cnt_en;

  assign wrap_o = synced_q && (ph_q == PH_LAST) && (bit_q == BIT_LAST) && (ch_q == CH_LAST);
  assign cnt_en = det_i || synced_q;

  always_comb begin
    ph_n     = ph_q;
    bit_n    = bit_q;
    ch_n     = ch_q;
    synced_n = synced_q;
    if (det_i) begin
      ph_n     = '0;
      bit_n    = '0;
      ch_n     = '0;
      synced_n = 1'b1;
    end else if (ph_q == PH_LAST) begin
      ph_n = '0;
      if (bit_q == BIT_LAST) begin
        bit_n = '0;
        ch_n  = (ch_q == CH_LAST) ? '0 : ch_q + 1'b1;
      end else begin
        bit_n = bit_q + 1'b1;
      end
    end else begin
      ph_n = ph_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q     <= '0;
      bit_q    <= '0;
      ch_q     <= '0;
      synced_q <= 1'b0;
    end else if (cnt_en) begin
      ph_q     <= ph_n;
      bit_q    <= bit_n;
      ch_q     <= ch_n;
      synced_q <= synced_n;
    end
  end

  always_comb begin
    frame_start_o = synced_q && (ph_q == '0) && (bit_q == '0) && (ch_q == '0);
    chan_o        = ch_q;
    bit_idx_o     = lsb_first_i ? bit_q : BIT_LAST - bit_q;
    drive_stb_o   = synced_q && (ph_q == '0);
    sample_stb_o  = synced_q && (ph_q == PH_SAMPLE);
  end

  // R3: the frame restarts right after a pulse is recognised
  a_r3_start_after_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    det_i |=> frame_start_o && (chan_o == '0));
  // R4: after the last phase of a bit, the next bit is driven
  a_r4_bit_rolls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (synced_q && (ph_q == PH_LAST) && !det_i) |=> drive_stb_o);
  // R4: channel steps by one after the last bit
  a_r4_chan_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (synced_q && !det_i && (ph_q == PH_LAST) && (bit_q == BIT_LAST) && (ch_q != CH_LAST))
      |=> (ch_q == $past(ch_q) + 1'b1));
  // R10: nothing moves before the first pulse
  a_r10_quiet_before_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!synced_q && !det_i) |=> (!drive_stb_o && !sample_stb_o && $stable(ch_q)));
endmodule

// File: rtl/fsd_lock_tracker.sv
module fsd_lock_tracker
  import fsd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       det_i,
  input  frame_fmt_e cand_i,
  input  logic       wrap_i,
  output logic       locked_o,
  output frame_fmt_e fmt_o
);
  frame_fmt_e hist_q, hist_n, fmt_q, fmt_n;
  logic       hist_v_q, hist_v_n, locked_q, locked_n;
  logic       agree;

  assign agree = det_i && wrap_i && hist_v_q && (hist_q == cand_i);

  always_comb begin
    hist_n   = hist_q;
    hist_v_n = hist_v_q;
    locked_n = locked_q;
    fmt_n    = fmt_q;
    if (det_i) begin
      hist_n   = cand_i;
      hist_v_n = 1'b1;
      locked_n = agree;
      if (agree) fmt_n = cand_i;
    end else if (wrap_i) begin
      locked_n = 1'b0;
      hist_v_n = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q   <= FMT_MSB_FIRST;
      hist_v_q <= 1'b0;
      locked_q <= 1'b0;
      fmt_q    <= FMT_MSB_FIRST;
    end else if (det_i || wrap_i) begin
      hist_q   <= hist_n;
      hist_v_q <= hist_v_n;
      locked_q <= locked_n;
      fmt_q    <= fmt_n;
    end
  end

  assign locked_o = locked_q;
  assign fmt_o    = fmt_q;

  // R6: lock only comes with a recognised pulse
  a_r6_lock_on_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_q) |-> $past(det_i));
  // R6: format moves only together with a lock
  a_r6_fmt_needs_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(fmt_q) |-> locked_q);
  // R7: polarity change drops the lock
  a_r7_mismatch_unlocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (det_i && hist_v_q && (hist_q != cand_i)) |=> !locked_q);
  // R8: missing pulse at the frame end drops the lock
  a_r8_miss_unlocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_i && !det_i) |=> !locked_q);
  // R9: pulse off the frame end drops the lock
  a_r9_misaligned_unlocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (det_i && !wrap_i) |=> !locked_q);
endmodule

// File: rtl/frame_fmt_detect.sv
module frame_fmt_detect
  import fsd_pkg::*;
#(
  parameter  int CHANNELS     = 32,
  parameter  int BITS_PER_CH  = 8,
  parameter  int CLKS_PER_BIT = 2,
  parameter  int SYNC_STAGES  = 2,
  localparam int CH_W  = $clog2(CHANNELS),
  localparam int BIT_W = $clog2(BITS_PER_CH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fp_i,
  output logic             fmt_o,
  output logic             not_locked_o,
  output logic             frame_start_o,
  output logic [CH_W-1:0]  chan_o,
  output logic [BIT_W-1:0] bit_idx_o,
  output logic             lsb_first_o,
  output logic             drive_stb_o,
  output logic             sample_stb_o
);
  // Reset: asserted at once, released on the clock
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_n;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_rst_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rst_sync_q[s] <= 1'b0;
      else         rst_sync_q[s] <= (s == 0) ? 1'b1 : rst_sync_q[(s == 0) ? 0 : s-1];
    end
  end
  assign rst_n = rst_sync_q[SYNC_STAGES-1];

  logic       det, wrap, locked;
  frame_fmt_e cand, fmt;

  fsd_pulse_classifier u_classify (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .fp_i   (fp_i),
    .det_o  (det),
    .cand_o (cand)
  );

  fsd_lock_tracker u_lock (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .det_i    (det),
    .cand_i   (cand),
    .wrap_i   (wrap),
    .locked_o (locked),
    .fmt_o    (fmt)
  );

  fsd_frame_counter #(
    .CHANNELS     (CHANNELS),
    .BITS_PER_CH  (BITS_PER_CH),
    .CLKS_PER_BIT (CLKS_PER_BIT)
  ) u_count (
    .clk_i         (clk_i),
    .rst_ni        (rst_n),
    .det_i         (det),
    .lsb_first_i   (fmt == FMT_LSB_FIRST),
    .wrap_o        (wrap),
    .frame_start_o (frame_start_o),
    .chan_o        (chan_o),
    .bit_idx_o     (bit_idx_o),
    .drive_stb_o   (drive_stb_o),
    .sample_stb_o  (sample_stb_o)
  );

  assign fmt_o        = fmt;
  assign lsb_first_o  = (fmt == FMT_LSB_FIRST);
  assign not_locked_o = !locked;

  // R4: a bit is never driven and sampled on the same clock
  a_r4_strobes_apart: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(drive_stb_o && sample_stb_o));
endmodule

// File: tb/frame_fmt_detect_tb.sv
module frame_fmt_detect_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       fp;
  logic       fmt, nl, fs, lsb, drv, smp;
  logic [4:0] chan;
  logic [2:0] bidx;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // model state (after the latest rising edge)
  bit m_syn, m_hv, m_hist, m_lock, m_fmt;
  int m_ph, m_bit, m_ch;
  bit h1, h2;
  // values captured at the last falling edge
  bit s_fs, s_nl, s_fmt, s_lsb;
  int s_chan;

  always #10 clk = ~clk;

  frame_fmt_detect u_dut (
    .clk_i(clk), .rst_ni(rst_n), .fp_i(fp),
    .fmt_o(fmt), .not_locked_o(nl), .frame_start_o(fs),
    .chan_o(chan), .bit_idx_o(bidx), .lsb_first_o(lsb),
    .drive_stb_o(drv), .sample_stb_o(smp)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_syn = 0; m_hv = 0; m_hist = 0; m_lock = 0; m_fmt = 0;
    m_ph = 0; m_bit = 0; m_ch = 0;
  endtask

  // One rising edge of the requirement model
  task automatic model_edge(input bit det, input bit cand);
    bit wrap;
    wrap = m_syn && m_ph == 1 && m_bit == 7 && m_ch == 31;
    if (det) begin
      if (wrap && m_hv && m_hist == cand) begin m_lock = 1; m_fmt = cand; end
      else m_lock = 0;
      m_hist = cand; m_hv = 1; m_syn = 1;
      m_ph = 0; m_bit = 0; m_ch = 0;
    end else if (m_syn) begin
      if (wrap) begin m_lock = 0; m_hv = 0; end
      m_ph = (m_ph + 1) % 2;
      if (m_ph == 0) begin
        m_bit = (m_bit + 1) % 8;
        if (m_bit == 0) m_ch = (m_ch + 1) % 32;
      end
    end
  endtask

  task automatic check_outputs();
    bit efs;
    efs = m_syn && m_ph == 0 && m_bit == 0 && m_ch == 0;
    chk("R3 frame_start", fs, efs);
    chk("R4 chan", chan, m_ch);
    chk("R4 drive_stb", drv, m_syn && m_ph == 0);
    chk("R4 sample_stb", smp, m_syn && m_ph == 1);
    chk("R5 bit_idx", bidx, m_fmt ? m_bit : 7 - m_bit);
    chk("R6 not_locked", nl, !m_lock);
    chk("R2 fmt", fmt, m_fmt);
    chk("R2 lsb_first", lsb, m_fmt);
    s_fs = fs; s_nl = nl; s_fmt = fmt; s_lsb = lsb; s_chan = chan;
  endtask

  task automatic step(input bit v);
    bit det;
    @(negedge clk);
    check_outputs();
    fp = v;
    det = (!h2 && h1 && !v) || (h2 && !h1 && v);
    model_edge(det, h1);
    h2 = h1; h1 = v;
  endtask

  // Idle level of the polarity, optional pulse three clocks before the end
  task automatic segment(input bit lsb_fmt, input bit with_pulse, input int len);
    bit idle;
    idle = !lsb_fmt;
    for (int i = 0; i < len; i++)
      step((with_pulse && i == len - 3) ? !idle : idle);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0D1F));
    rst_n = 1'b0; fp = 1'b1;
    model_reset();
    h1 = 1; h2 = 1;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 not_locked", nl, 1);
    chk("R1 fmt", fmt, 0);
    chk("R1 frame_start", fs, 0);
    chk("R1 strobes", {drv, smp}, 0);
    chk("R1 chan", chan, 0);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);

    // R10: long idle, nothing moves
    segment(0, 0, 60);
    chk("R10 chan idle", s_chan, 0);
    chk("R10 no strobe", {drv, smp}, 0);
    chk("R10 still unlocked", s_nl, 1);

    // R3/R6: first active-low pulse starts the frame, no lock yet
    segment(0, 1, 20);
    chk("R3 frame start", s_fs, 1);
    chk("R3 chan zero", s_chan, 0);
    chk("R6 one pulse not locked", s_nl, 1);
    segment(0, 1, 512);
    chk("R6 locked after two", s_nl, 0);
    chk("R2 msb-first fmt", s_fmt, 0);
    segment(0, 1, 512);

    // R7: polarity change drops lock, format kept
    segment(1, 1, 512);
    chk("R7 mismatch unlocked", s_nl, 1);
    chk("R7 fmt kept", s_fmt, 0);
    segment(1, 1, 512);
    chk("R6 relock", s_nl, 0);
    chk("R2 lsb-first fmt", s_fmt, 1);
    chk("R5 lsb_first", s_lsb, 1);

    // R8: missing pulse
    segment(1, 0, 512);
    chk("R8 flywheel start", s_fs, 1);
    chk("R8 unlocked", s_nl, 1);
    segment(1, 1, 512);
    chk("R8 first after gap", s_nl, 1);
    segment(1, 1, 512);
    chk("R8 relocked", s_nl, 0);

    // R9: misaligned pulse
    segment(1, 1, 300);
    chk("R9 realigned", s_fs, 1);
    chk("R9 chan zero", s_chan, 0);
    chk("R9 unlocked", s_nl, 1);
    segment(1, 1, 512);
    chk("R9 relock", s_nl, 0);

    // random frames
    for (int f = 0; f < 30; f++) begin
      bit pf, pp;
      int len;
      pf  = ($urandom_range(0, 3) == 0) ? !s_fmt : s_fmt;
      pp  = ($urandom_range(0, 9) != 0);
      len = ($urandom_range(0, 9) == 0) ? $urandom_range(20, 600) : 512;
      segment(pf, pp, len);
    end
    segment(0, 1, 512);
    segment(0, 1, 512);
    chk("R6 final lock", s_nl, 0);
    chk("R2 final fmt", s_fmt, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule